// File: doc/BRIEF.md
# Flag-Polled Byte Input Port

This block is a single-byte input channel on the bus of a simple 8-bit processor. An operator or an attached device presents a byte on eight active-low switch lines and gives a one-shot enter strobe. The block then pulls an active-low external flag, which the program polls. When the flag is seen low, the program runs this port's input instruction. In the input/output transfer cycle of that instruction, the block drives the byte onto the data bus. The flag returns high at the address-timing pulse of that cycle, so each press delivers exactly one byte.

The port can be selected in two ways, fixed by a parameter. In the sparse mode, any input-group instruction with N bit 3 set selects the port. In the decoded mode, only one full N value selects it (9 by default). This leaves the other input-group codes with N bit 3 set free for other channels. The data bus is modelled as a data vector plus an output-enable that a pad cell turns into tri-state drive.

Top module: `flag_byte_in`

## Requirements
- R1: After reset, `ef_no` is high and `bus_oe_o` is low.
- R2: A rising edge on `enter_i` drives `ef_no` low after the third rising clock edge that follows the rise (two synchroniser stages plus one edge register).
- R3: An `enter_i` held high across many cycles sets the flag only once. After that flag is cleared, it stays high while `enter_i` stays high.
- R4: A press that occurs while `ef_no` is already low is ignored. One clear returns the flag high, and the flag stays high afterwards.
- R5: `ef_no` returns high after a clock edge at which `tpa_i` is high while the port is selected in a transfer cycle. A `tpa_i` pulse outside that condition leaves the flag unchanged.
- R6: A transfer cycle is `sc_i[1]`=1 with `sc_i[0]`=0. `bus_oe_o` is never high with any other state code.
- R7: In sparse mode (`DECODED_SEL`=0), the port is selected when `i_code_i`=6 and `n_code_i[3]`=1.
- R8: In decoded mode (`DECODED_SEL`=1), the port is selected only when `i_code_i`=6 and `n_code_i` equals `SEL_N` (9). N codes 8 and A through F do not select it.
- R9: While `bus_oe_o` is high, `bus_o` is the bitwise inverse of `sw_ni`, because a closed switch pulls its line low to encode a 1. While `bus_oe_o` is low, `bus_o` is all zero.
- R10: When an enter edge and a clearing `tpa_i` act on the same clock edge, the clear wins, the press is dropped, and `ef_no` ends high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_ni | input | 8 | Switch byte, low level = 1 |
| enter_i | input | 1 | Enter strobe, asynchronous, active high |
| i_code_i | input | 4 | Instruction group code I |
| n_code_i | input | 4 | Instruction N code |
| sc_i | input | 2 | State code, bit 1 = SC1, bit 0 = SC0 |
| tpa_i | input | 1 | Address-timing pulse |
| bus_o | output | 8 | Byte for the data bus |
| bus_oe_o | output | 1 | Data bus drive enable (high impedance when low) |
| ef_no | output | 1 | External flag, active low |

## Verification
A fresh enter edge and the clearing address-timing pulse can reach the flag register on the same clock edge. The bench provokes this by starting a press and then timing the transfer-cycle pulse onto the third clock edge after the rise, when the edge detector fires. It judges the outcome at the flag pin. The flag must be high right after that edge and must still be high several cycles later, which proves the press was dropped and not queued.

// File: rtl/byte_in_pkg.sv
package byte_in_pkg;
  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] IO_IN_GROUP = 4'h6;

  typedef enum logic [1:0] {
    SC_FETCH = 2'b00,
    SC_EXEC  = 2'b01,
    SC_XFER  = 2'b10,
    SC_INTR  = 2'b11
  } state_code_e;
endpackage

// File: rtl/enter_sync.sv
module enter_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= strobe_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], strobe_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;

  // a held strobe yields a single pulse
  p_single_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/port_decode.sv
module port_decode
  import byte_in_pkg::*;
#(
  parameter bit              DECODED_SEL = 1'b1,
  parameter logic [CODE_W-1:0] SEL_N     = 4'h9
) (
  input  logic [CODE_W-1:0] i_code_i,
  input  logic [CODE_W-1:0] n_code_i,
  input  logic [1:0]        sc_i,
  output logic              match_o,
  output logic              xfer_o
);
  logic group_hit;
  assign group_hit = (i_code_i == IO_IN_GROUP);

  generate
    if (DECODED_SEL) begin : g_full
      assign match_o = group_hit && (n_code_i == SEL_N);
    end else begin : g_sparse
      assign match_o = group_hit && n_code_i[CODE_W-1];
    end
  endgenerate

  assign xfer_o = (sc_i == SC_XFER);
endmodule

// File: rtl/flag_ctrl.sv
module flag_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic clr_i,
  output logic pending_o
);
  // clear dominates a coincident set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pending_o <= 1'b0;
    else if (clr_i)  pending_o <= 1'b0;
    else if (rise_i) pending_o <= 1'b1;
  end

  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !pending_o);
  p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && !clr_i) |=> pending_o);
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_o && !clr_i) |=> pending_o);
  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pending_o && !rise_i) |=> !pending_o);
endmodule

// File: rtl/flag_byte_in.sv
module flag_byte_in
  import byte_in_pkg::*;
#(
  parameter int                BYTE_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter bit                DECODED_SEL = 1'b1,
  parameter logic [CODE_W-1:0] SEL_N       = 4'h9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] sw_ni,
  input  logic              enter_i,
  input  logic [CODE_W-1:0] i_code_i,
  input  logic [CODE_W-1:0] n_code_i,
  input  logic [1:0]        sc_i,
  input  logic              tpa_i,
  output logic [BYTE_W-1:0] bus_o,
  output logic              bus_oe_o,
  output logic              ef_no
);
  logic rise, match, xfer, drive, clr, pending;

  enter_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(enter_i),
    .rise_o  (rise)
  );

  port_decode #(.DECODED_SEL(DECODED_SEL), .SEL_N(SEL_N)) u_dec (
    .i_code_i(i_code_i),
    .n_code_i(n_code_i),
    .sc_i    (sc_i),
    .match_o (match),
    .xfer_o  (xfer)
  );

  assign drive = match & xfer;
  assign clr   = drive & tpa_i;

  flag_ctrl u_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise_i   (rise),
    .clr_i    (clr),
    .pending_o(pending)
  );

  assign ef_no    = ~pending;
  assign bus_oe_o = drive;
  // closed switch reads low and stands for a 1
  assign bus_o    = drive ? ~sw_ni : '0;

  p_oe_state_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> (sc_i == SC_XFER));
  p_oe_group_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> (i_code_i == IO_IN_GROUP));
  p_tpa_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tpa_i && bus_oe_o) |=> ef_no);
endmodule

// File: tb/test_flag_byte_in.sv
module test_flag_byte_in;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sw_n = 8'hff;
  logic       enter = 1'b0;
  logic [3:0] i_code = '0, n_code = '0;
  logic [1:0] sc = 2'b00;
  logic       tpa = 1'b0;
  logic [7:0] bus_d, bus_s;
  logic       oe_d, oe_s, ef_d, ef_s;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flag_byte_in #(.DECODED_SEL(1'b1)) i_flag_byte_in (
    .clk_i(clk), .rst_ni(rst_n), .sw_ni(sw_n), .enter_i(enter),
    .i_code_i(i_code), .n_code_i(n_code), .sc_i(sc), .tpa_i(tpa),
    .bus_o(bus_d), .bus_oe_o(oe_d), .ef_no(ef_d));

  flag_byte_in #(.DECODED_SEL(1'b0)) i_flag_byte_in_sparse (
    .clk_i(clk), .rst_ni(rst_n), .sw_ni(sw_n), .enter_i(enter),
    .i_code_i(i_code), .n_code_i(n_code), .sc_i(sc), .tpa_i(tpa),
    .bus_o(bus_s), .bus_oe_o(oe_s), .ef_no(ef_s));

  function automatic bit exp_oe(bit dec, logic [3:0] i, logic [3:0] n, logic [1:0] s);
    return (s == 2'b10) && (i == 4'h6) && (dec ? (n == 4'h9) : n[3]);
  endfunction

  function automatic logic [7:0] exp_bus(bit en, logic [7:0] sw);
    return en ? ~sw : 8'h00;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(int k);
    repeat (k) @(negedge clk);
  endtask

  // one-cycle clearing pulse in a selecting transfer cycle
  task automatic clear_pulse();
    sc = 2'b10; i_code = 4'h6; n_code = 4'h9; tpa = 1'b1;
    @(negedge clk);
    sc = 2'b00; i_code = 4'h0; n_code = 4'h0; tpa = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 flag dec", ef_d, 1); chk("R1 flag sparse", ef_s, 1);
    chk("R1 oe", {oe_d, oe_s}, 0);

    // R2: latency of three edges
    enter = 1'b1;
    cyc(2);
    chk("R2 flag still high after two edges", ef_d, 1);
    cyc(1);
    chk("R2 flag low after third edge", {ef_d, ef_s}, 0);

    // R5: tpa outside transfer cycle does not clear
    sc = 2'b01; i_code = 4'h6; n_code = 4'h9; tpa = 1'b1;
    cyc(1);
    tpa = 1'b0; sc = 2'b00;
    chk("R5 tpa outside transfer keeps flag", {ef_d, ef_s}, 0);
    clear_pulse();
    chk("R5 clear at tpa", {ef_d, ef_s}, 2'b11);

    // R3: still held, no second set
    cyc(10);
    chk("R3 held enter sets once", {ef_d, ef_s}, 2'b11);
    enter = 1'b0;
    cyc(4);

    // R4: second press while low is ignored
    enter = 1'b1; cyc(2); enter = 1'b0; cyc(3);
    chk("R4 first press", ef_d, 0);
    enter = 1'b1; cyc(2); enter = 1'b0; cyc(4);
    chk("R4 flag stays low", ef_d, 0);
    clear_pulse();
    cyc(6);
    chk("R4 second press not queued", {ef_d, ef_s}, 2'b11);

    // R10: edge and clear on the same clock edge
    enter = 1'b1;
    cyc(2);
    sc = 2'b10; i_code = 4'h6; n_code = 4'h9; tpa = 1'b1;
    cyc(1);
    sc = 2'b00; i_code = 4'h0; n_code = 4'h0; tpa = 1'b0;
    chk("R10 clear wins at coincidence", {ef_d, ef_s}, 2'b11);
    cyc(5);
    chk("R10 press dropped", {ef_d, ef_s}, 2'b11);
    enter = 1'b0;
    cyc(4);

    // R8 / R7: directed sweep of N in the input group
    for (int n = 8; n < 16; n++) begin
      sc = 2'b10; i_code = 4'h6; n_code = n[3:0]; sw_n = 8'h3c;
      #1;
      chk("R8 decoded select", oe_d, (n == 9));
      chk("R7 sparse select", oe_s, 1);
      chk("R9 bus inverse", bus_s, 8'hc3);
      @(negedge clk);
    end

    // R6..R9: constrained random decode and data
    for (int k = 0; k < 400; k++) begin
      i_code = ($urandom_range(0, 1) == 1) ? 4'h6 : 4'($urandom_range(0, 15));
      n_code = 4'($urandom_range(0, 15));
      sc = ($urandom_range(0, 1) == 1) ? 2'b10 : 2'($urandom_range(0, 3));
      sw_n = 8'($urandom_range(0, 255));
      #1;
      chk("R6 R8 oe decoded", oe_d, exp_oe(1'b1, i_code, n_code, sc));
      chk("R6 R7 oe sparse", oe_s, exp_oe(1'b0, i_code, n_code, sc));
      chk("R9 bus decoded", bus_d, exp_bus(exp_oe(1'b1, i_code, n_code, sc), sw_n));
      chk("R9 bus sparse", bus_s, exp_bus(exp_oe(1'b0, i_code, n_code, sc), sw_n));
      @(negedge clk);
    end
    chk("R1 flag untouched by decode traffic", {ef_d, ef_s}, 2'b11);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule